// File: doc/BRIEF.md
# Shadowed LCD Timing Generator

This block drives a parallel RGB panel's horizontal sync, vertical sync, data-enable and pixel-clock pins, and reports the current scan position. Every timing length is programmed as the wanted count minus one: sync width, back porch and front porch for each direction, plus the active pixels per line and the active lines per frame. A line is laid out as sync, back porch, active, then front porch, and a frame has the same layout counted in lines. A pixel tick enable, produced by a programmable divider or passed 1:1, advances the counters.

Software writes through a plain register write port. Timing, divider and output-enable fields land in a pending copy. That copy moves into the working set only at a frame boundary, and a protect bit can hold off the move. While the output is disabled the counters stay at zero and every pixel tick counts as a frame boundary, so an enable takes effect on the next tick. Polarity inversion, the protect bit and the interrupt controls take effect at once. A frame interrupt latches a pending flag at each frame boundary reached while the output runs. The register port carries configuration only, not a data stream, so it has no valid/ready handshake and applies one write per cycle while `wr_en` is high.

Register map, where the address is `wr_addr` and the bits are from `wr_data`. Address 0 holds output enable at bit 0, divider enable at bit 1 and the divide value at bits 15:8. Address 1 holds vertical back porch at bits 7:0, front porch at bits 15:8 and sync width at bits 23:16. Address 2 uses the same layout for the horizontal direction. Address 3 holds active pixels per line at bits CNT_W-1:0 and active lines at bits 16+CNT_W-1:16. Address 4 holds global interrupt enable at bit 0, frame interrupt enable at bit 1 and the trigger select at bits 3:2. Address 5 clears the pending flag when bit 0 is written as 1. Address 6 holds protect at bit 0 and the inversion bits at bits 7:4, in the order hsync, vsync, data-enable, pixel clock. Addresses 0 to 3 are pending and the rest are immediate.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset hsync_o, vsync_o, de_o and irq_o are 0, h_pos_o and v_pos_o are 0, pix_tick_o is 1 on every clock, and the pending and working copies hold zeros with output disabled.
- R2: With output enabled, a line lasts (hsw+1)+(hbp+1)+(hact+1)+(hfp+1) pixel ticks, and hsync is active for the first hsw+1 ticks of each line.
- R3: A frame lasts (vsw+1)+(vbp+1)+(vact+1)+(vfp+1) lines, and vsync is active for the whole of its first vsw+1 lines.
- R4: de is active only when the horizontal position is in [hsw+hbp+2, hsw+hbp+hact+3) and the vertical position is in the same range built from the vertical fields.
- R5: With divider enable 1, pix_tick_o pulses once every clkval+1 clocks. With divider enable 0, it pulses every clock. pclk_o is high when the divider phase is at least half the divisor, rounded down.
- R6: Writes to addresses 0 to 3 leave the outputs unchanged until the next frame boundary, and at that boundary they all take effect together.
- R7: While protect is 1, frame boundaries do not apply pending values. The first boundary after protect returns to 0 applies them.
- R8: Inversion bits 4, 5, 6 and 7 of address 6 each invert only hsync_o, vsync_o, de_o and pclk_o respectively, starting the cycle after the write.
- R9: The pending flag (irq_o) sets at a frame boundary reached while output is enabled, only if global enable, frame enable and trigger select 2'b01 (vsync) are all set.
- R10: Writing 1 to bit 0 of address 5 clears the pending flag, and writing 0 leaves it set. A set in the same cycle wins over a clear.
- R11: h_pos_o and v_pos_o give the current pixel and line, step on each pixel tick while enabled, and return to 0 at the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pclk_o | output | 1 | Pixel clock level after polarity |
| pix_tick_o | output | 1 | One-clock pixel advance pulse |
| h_pos_o | output | CNT_W+2 | Current pixel within the line |
| v_pos_o | output | CNT_W+2 | Current line within the frame |
| irq_o | output | 1 | Frame interrupt pending |

## Verification
The bench builds the block with CNT_W = 8, which keeps the counter and position widths at 10 bits. It programs an 8-pixel by 5-line frame, so a whole frame takes only 40 to 120 clocks. This makes several frame boundaries, protect windows, divider changes and interrupt cycles possible within one short run. It also checks the shortest single-tick sync and porch fields and the divide-by-three pixel clock against a behavioural model on every clock.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int PORCH_W = 8;
  localparam int DIV_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_VTIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_HTIM = 3'd2;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
  localparam logic [ADDR_W-1:0] A_ICFG = 3'd4;
  localparam logic [ADDR_W-1:0] A_ICLR = 3'd5;
  localparam logic [ADDR_W-1:0] A_MISC = 3'd6;

  localparam logic [1:0] TRIG_VSYNC = 2'b01;

  typedef struct packed {
    logic               out_en;
    logic               div_en;
    logic [DIV_W-1:0]   clkval;
    logic [PORCH_W-1:0] vsw, vbp, vfp;
    logic [PORCH_W-1:0] hsw, hbp, hfp;
  } tcfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boundary,
  input  logic              frame_done,
  output tcfg_t             act,
  output logic [CNT_W-1:0]  act_hact,
  output logic [CNT_W-1:0]  act_vact,
  output logic [3:0]        inv,
  output logic              irq
);
  tcfg_t            sh;
  logic [CNT_W-1:0] sh_hact, sh_vact;
  logic             protect, gie, fie, pend;
  logic [1:0]       trig;
  logic             set_irq, clr_irq;

  assign set_irq = frame_done && gie && fie && (trig == TRIG_VSYNC);
  assign clr_irq = wr_en && (wr_addr == A_ICLR) && wr_data[0];
  assign irq     = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; sh_hact <= '0; sh_vact <= '0;
      act <= '0; act_hact <= '0; act_vact <= '0;
      protect <= 1'b0; inv <= '0; gie <= 1'b0; fie <= 1'b0; trig <= '0;
    end else begin
      if (boundary && !protect) begin
        act      <= sh;
        act_hact <= sh_hact;
        act_vact <= sh_vact;
      end
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            sh.out_en <= wr_data[0];
            sh.div_en <= wr_data[1];
            sh.clkval <= wr_data[8 +: DIV_W];
          end
          A_VTIM: begin
            sh.vbp <= wr_data[0 +: PORCH_W];
            sh.vfp <= wr_data[8 +: PORCH_W];
            sh.vsw <= wr_data[16 +: PORCH_W];
          end
          A_HTIM: begin
            sh.hbp <= wr_data[0 +: PORCH_W];
            sh.hfp <= wr_data[8 +: PORCH_W];
            sh.hsw <= wr_data[16 +: PORCH_W];
          end
          A_SIZE: begin
            sh_hact <= wr_data[0 +: CNT_W];
            sh_vact <= wr_data[16 +: CNT_W];
          end
          A_ICFG: begin
            gie  <= wr_data[0];
            fie  <= wr_data[1];
            trig <= wr_data[3:2];
          end
          A_MISC: begin
            protect <= wr_data[0];
            inv     <= wr_data[7:4];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (set_irq)  pend <= 1'b1;
    else if (clr_irq)  pend <= 1'b0;
  end

  logic unused_wdata;
  assign unused_wdata = ^{1'b0, wr_data};

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act) && $stable(act_hact) && $stable(act_vact));
  // R7
  protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && protect) |=> $stable(act) && $stable(act_hact) && $stable(act_vact));
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(frame_done && gie && fie && trig == TRIG_VSYNC));
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ICLR && wr_data[0] && !frame_done) |=> !pend);
endmodule

// File: rtl/lcd_tg_pclk.sv
module lcd_tg_pclk
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_en,
  input  logic [DIV_W-1:0] clkval,
  output logic             tick,
  output logic             lvl
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W:0]   div_n;

  assign div_n = div_en ? ({1'b0, clkval} + 1'b1) : (DIV_W+1)'(1);
  assign tick  = ({1'b0, phase} == div_n - 1'b1);
  assign lvl   = ({1'b0, phase} >= (div_n >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_n > 1) |=> (!tick || div_n == 1));
endmodule

// File: rtl/lcd_tg_scan.sv
module lcd_tg_scan
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int TOT_W = ((CNT_W > PORCH_W) ? CNT_W : PORCH_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tcfg_t            cfg,
  input  logic [CNT_W-1:0] hact,
  input  logic [CNT_W-1:0] vact,
  output logic             boundary,
  output logic             hs_raw,
  output logic             vs_raw,
  output logic             de_raw,
  output logic [TOT_W-1:0] hpos,
  output logic [TOT_W-1:0] vpos
);
  logic             run, h_last, v_last, h_in, v_in;
  logic [TOT_W-1:0] htot, vtot, h_beg, v_beg, h_end, v_end;

  assign run   = cfg.out_en;
  assign htot  = TOT_W'(cfg.hsw) + TOT_W'(cfg.hbp) + TOT_W'(hact) + TOT_W'(cfg.hfp) + TOT_W'(4);
  assign vtot  = TOT_W'(cfg.vsw) + TOT_W'(cfg.vbp) + TOT_W'(vact) + TOT_W'(cfg.vfp) + TOT_W'(4);
  assign h_beg = TOT_W'(cfg.hsw) + TOT_W'(cfg.hbp) + TOT_W'(2);
  assign v_beg = TOT_W'(cfg.vsw) + TOT_W'(cfg.vbp) + TOT_W'(2);
  assign h_end = h_beg + TOT_W'(hact) + TOT_W'(1);
  assign v_end = v_beg + TOT_W'(vact) + TOT_W'(1);

  assign h_last   = (hpos == htot - 1'b1);
  assign v_last   = (vpos == vtot - 1'b1);
  assign boundary = tick && (!run || (h_last && v_last));

  assign h_in   = (hpos >= h_beg) && (hpos < h_end);
  assign v_in   = (vpos >= v_beg) && (vpos < v_end);
  assign hs_raw = run && (hpos <= TOT_W'(cfg.hsw));
  assign vs_raw = run && (vpos <= TOT_W'(cfg.vsw));
  assign de_raw = run && h_in && v_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (boundary) begin
      hpos <= '0;
      vpos <= '0;
    end else if (tick && run) begin
      if (h_last) begin
        hpos <= '0;
        vpos <= vpos + 1'b1;
      end else begin
        hpos <= hpos + 1'b1;
      end
    end
  end

  // R2
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> hpos < htot);
  // R4
  de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !hs_raw && !vs_raw);
  // R1
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hpos == '0) && (vpos == '0));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W = 12,
  localparam int TOT_W = ((CNT_W > PORCH_W) ? CNT_W : PORCH_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_o,
  output logic              pix_tick_o,
  output logic [TOT_W-1:0]  h_pos_o,
  output logic [TOT_W-1:0]  v_pos_o,
  output logic              irq_o
);
  tcfg_t            act;
  logic [CNT_W-1:0] act_hact, act_vact;
  logic [3:0]       inv;
  logic             boundary, tick, lvl, hs_raw, vs_raw, de_raw;

  lcd_tg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boundary(boundary), .frame_done(boundary && act.out_en),
    .act(act), .act_hact(act_hact), .act_vact(act_vact), .inv(inv), .irq(irq_o)
  );

  lcd_tg_pclk u_pclk (
    .clk(clk), .rst_n(rst_n), .div_en(act.div_en), .clkval(act.clkval),
    .tick(tick), .lvl(lvl)
  );

  lcd_tg_scan #(.CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(act), .hact(act_hact), .vact(act_vact),
    .boundary(boundary), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
    .hpos(h_pos_o), .vpos(v_pos_o)
  );

  assign hsync_o    = hs_raw ^ inv[0];
  assign vsync_o    = vs_raw ^ inv[1];
  assign de_o       = de_raw ^ inv[2];
  assign pclk_o     = lvl ^ inv[3];
  assign pix_tick_o = tick;
endmodule

// File: tb/sim_lcd_sync_gen.sv
`timescale 1ns/1ps
module sim_lcd_sync_gen;
  localparam int CNT_W = 8;
  localparam int TOT_W = CNT_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync_o, vsync_o, de_o, pclk_o, pix_tick_o, irq_o;
  logic [TOT_W-1:0] h_pos_o, v_pos_o;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  lcd_sync_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o),
    .pix_tick_o(pix_tick_o), .h_pos_o(h_pos_o), .v_pos_o(v_pos_o), .irq_o(irq_o)
  );

  // behavioural reference state
  int s_oe, s_de, s_cv, s_vsw, s_vbp, s_vfp, s_hsw, s_hbp, s_hfp, s_ha, s_va;
  int a_oe, a_de, a_cv, a_vsw, a_vbp, a_vfp, a_hsw, a_hbp, a_hfp, a_ha, a_va;
  int m_prot, m_inv, m_gie, m_fie, m_trig, m_pend, m_ph, m_h, m_v;

  always @(posedge clk or negedge rst_n) begin
    int n, htot, vtot;
    bit tk, bnd;
    if (!rst_n) begin
      s_oe = 0; s_de = 0; s_cv = 0; s_vsw = 0; s_vbp = 0; s_vfp = 0;
      s_hsw = 0; s_hbp = 0; s_hfp = 0; s_ha = 0; s_va = 0;
      a_oe = 0; a_de = 0; a_cv = 0; a_vsw = 0; a_vbp = 0; a_vfp = 0;
      a_hsw = 0; a_hbp = 0; a_hfp = 0; a_ha = 0; a_va = 0;
      m_prot = 0; m_inv = 0; m_gie = 0; m_fie = 0; m_trig = 0;
      m_pend = 0; m_ph = 0; m_h = 0; m_v = 0;
    end else begin
      n    = a_de ? a_cv + 1 : 1;
      tk   = (m_ph == n - 1);
      htot = a_hsw + a_hbp + a_ha + a_hfp + 4;
      vtot = a_vsw + a_vbp + a_va + a_vfp + 4;
      bnd  = tk && (a_oe == 0 || (m_h == htot - 1 && m_v == vtot - 1));
      if (bnd && a_oe != 0 && m_gie != 0 && m_fie != 0 && m_trig == 1) m_pend = 1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_pend = 0;
      m_ph = tk ? 0 : m_ph + 1;
      if (bnd) begin m_h = 0; m_v = 0; end
      else if (tk && a_oe != 0) begin
        if (m_h == htot - 1) begin m_h = 0; m_v = m_v + 1; end
        else m_h = m_h + 1;
      end
      if (bnd && m_prot == 0) begin
        a_oe = s_oe; a_de = s_de; a_cv = s_cv; a_vsw = s_vsw; a_vbp = s_vbp;
        a_vfp = s_vfp; a_hsw = s_hsw; a_hbp = s_hbp; a_hfp = s_hfp; a_ha = s_ha; a_va = s_va;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin s_oe = int'(wr_data[0]); s_de = int'(wr_data[1]); s_cv = int'(wr_data[15:8]); end
          3'd1: begin s_vbp = int'(wr_data[7:0]); s_vfp = int'(wr_data[15:8]); s_vsw = int'(wr_data[23:16]); end
          3'd2: begin s_hbp = int'(wr_data[7:0]); s_hfp = int'(wr_data[15:8]); s_hsw = int'(wr_data[23:16]); end
          3'd3: begin s_ha = int'(wr_data[7:0]); s_va = int'(wr_data[23:16]); end
          3'd4: begin m_gie = int'(wr_data[0]); m_fie = int'(wr_data[1]); m_trig = int'(wr_data[3:2]); end
          3'd6: begin m_prot = int'(wr_data[0]); m_inv = int'(wr_data[7:4]); end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    int n, hb, vb, e_hs, e_vs, e_de, e_pc, e_tk;
    if (cmp_on && rst_n) begin
      n  = a_de ? a_cv + 1 : 1;
      hb = a_hsw + a_hbp + 2;
      vb = a_vsw + a_vbp + 2;
      e_hs = ((a_oe != 0 && m_h <= a_hsw) ? 1 : 0) ^ (m_inv & 1);
      e_vs = ((a_oe != 0 && m_v <= a_vsw) ? 1 : 0) ^ ((m_inv >> 1) & 1);
      e_de = ((a_oe != 0 && m_h >= hb && m_h < hb + a_ha + 1 &&
               m_v >= vb && m_v < vb + a_va + 1) ? 1 : 0) ^ ((m_inv >> 2) & 1);
      e_pc = ((m_ph >= n / 2) ? 1 : 0) ^ ((m_inv >> 3) & 1);
      e_tk = (m_ph == n - 1) ? 1 : 0;
      chk(int'(hsync_o) == e_hs, "R2 hsync", int'(hsync_o), e_hs);
      chk(int'(vsync_o) == e_vs, "R3 vsync", int'(vsync_o), e_vs);
      chk(int'(de_o) == e_de, "R4 de", int'(de_o), e_de);
      chk(int'(pclk_o) == e_pc, "R5 pclk", int'(pclk_o), e_pc);
      chk(int'(pix_tick_o) == e_tk, "R5 tick", int'(pix_tick_o), e_tk);
      chk(int'(h_pos_o) == m_h, "R11 hpos", int'(h_pos_o), m_h);
      chk(int'(v_pos_o) == m_v, "R11 vpos", int'(v_pos_o), m_v);
      chk(int'(irq_o) == m_pend, "R9 irq", int'(irq_o), m_pend);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_vs_rise();
    logic p;
    p = vsync_o;
    forever begin
      @(negedge clk);
      if (vsync_o && !p) break;
      p = vsync_o;
    end
  endtask

  task automatic hs_width(output int w);
    logic p;
    p = hsync_o;
    forever begin
      @(negedge clk);
      if (hsync_o && !p) break;
      p = hsync_o;
    end
    w = 0;
    while (hsync_o) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run hung");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R1 sync/de low", int'({hsync_o, vsync_o, de_o}), 0);
    chk(irq_o == 0, "R1 irq low", int'(irq_o), 0);
    chk(h_pos_o == 0 && v_pos_o == 0, "R1 position zero", int'(h_pos_o), 0);
    chk(pix_tick_o == 1, "R1 tick every clock", int'(pix_tick_o), 1);

    // timing: hsw 2, hbp 1, hact 4, hfp 1; vsw 1, vbp 1, vact 2, vfp 1
    wr(3'd2, 32'h0001_0000);
    wr(3'd1, 32'h0000_0000);
    wr(3'd3, 32'h0001_0003);
    wr(3'd0, 32'h0000_0001);
    wait_vs_rise();

    // R6 pending write not visible until boundary
    wr(3'd2, 32'h0003_0000);
    hs_width(w);
    chk(w == 2, "R6 old hsync width kept", w, 2);
    wait_vs_rise();
    hs_width(w);
    chk(w == 4, "R6 new hsync width at boundary", w, 4);

    // R7 protect holds the transfer
    wr(3'd6, 32'h0000_0001);
    wr(3'd2, 32'h0000_0000);
    wait_vs_rise();
    wait_vs_rise();
    hs_width(w);
    chk(w == 4, "R7 protected width kept", w, 4);
    wr(3'd6, 32'h0000_0000);
    wait_vs_rise();
    hs_width(w);
    chk(w == 1, "R7 applied after unprotect", w, 1);

    // R5 divider by three
    wr(3'd0, 32'h0000_0203);
    wait_vs_rise();
    while (!pix_tick_o) @(negedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!pix_tick_o);
    chk(cnt == 3, "R5 tick spacing", cnt, 3);

    // R9 interrupt gating
    wr(3'd4, 32'h0000_0003);
    wait_vs_rise();
    wait_vs_rise();
    @(negedge clk);
    chk(irq_o == 0, "R9 wrong trigger select", int'(irq_o), 0);
    wr(3'd4, 32'h0000_0005);
    wait_vs_rise();
    @(negedge clk);
    chk(irq_o == 0, "R9 frame enable off", int'(irq_o), 0);
    wr(3'd4, 32'h0000_0007);
    wait_vs_rise();
    @(negedge clk);
    chk(irq_o == 1, "R9 pending set at frame boundary", int'(irq_o), 1);

    // R10 write-one-to-clear
    wr(3'd5, 32'h0000_0000);
    @(negedge clk);
    chk(irq_o == 1, "R10 write zero keeps pending", int'(irq_o), 1);
    wr(3'd5, 32'h0000_0001);
    @(negedge clk);
    chk(irq_o == 0, "R10 write one clears", int'(irq_o), 0);
    wr(3'd4, 32'h0000_0000);

    // disable output, then R8 polarity
    wr(3'd0, 32'h0000_0000);
    repeat (200) @(negedge clk);
    chk(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R1 idle outputs inactive",
        int'({hsync_o, vsync_o, de_o}), 0);
    wr(3'd6, 32'h0000_0070);
    chk(hsync_o == 1 && vsync_o == 1 && de_o == 1, "R8 three inverted",
        int'({hsync_o, vsync_o, de_o}), 7);
    wr(3'd6, 32'h0000_0020);
    chk(hsync_o == 0 && vsync_o == 1 && de_o == 0, "R8 vsync only",
        int'({hsync_o, vsync_o, de_o}), 2);
    wr(3'd6, 32'h0000_0080);
    chk(pclk_o == 0 && hsync_o == 0, "R8 pclk only", int'({pclk_o, hsync_o}), 0);
    repeat (10) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule